// File: doc/BRIEF.md
# Mode-Switched Serial Receive Queue

This block holds received bytes for a PC-style serial port controller until the host reads them through the data register. It runs in one of two modes, selected by the enable bit of the FIFO control register. In legacy single-character mode it keeps one byte. In queued mode it keeps up to sixteen bytes. Bytes arrive on a push interface, either from the receive shifter or from the loopback path. They leave on a pop interface that a data-register read drives.

The block also keeps the write side of the FIFO control register. A write that changes the mode, or that asks for a receive reset while queued mode is on, empties the queue. The byte source is told to hold off while the queue is full. A push into a full queue is refused and reported. When the refused push came from the loopback path, it is reported as an overrun.

Top module: `rx_queue`

## Requirements
- R1: After reset the block is in legacy mode (`fifo_mode`=0) and holds no bytes. The capacity is 1 in legacy mode and 16 in queued mode, where queued mode is bit 0 of the stored control value.
- R2: A control write whose bit 0 differs from the current mode empties the queue in the next cycle, and the new mode sets the capacity.
- R3: A control write with bit 0 = 1 and bit 1 (receive reset) = 1 empties the queue and leaves queued mode on. A write of bit 0 = 1 with bit 1 = 0 while already in queued mode keeps the contents.
- R4: A control write with bit 0 = 0 stores 0x00. Any other control write stores the written value AND 0xC9, which keeps bits 0, 3, 6 and 7.
- R5: A push while the queue is full and no flush is in progress is refused, and `push_reject` is high in that cycle. `overrun` is high in that cycle as well when `push_lb` is set.
- R6: `push_ready` is low exactly while the queue holds its capacity. It rises in the cycle after one pop from a full queue.
- R7: A pop from an empty queue changes no state, and `pop_data` reads 0xFF.
- R8: Bytes leave in the order they were accepted, and the storage positions wrap around through the capacity repeatedly.
- R9: An accepted push and a valid pop in the same cycle leave the count unchanged. A flushing control write in the same cycle as a push or a pop overrides both, and the queue ends empty.
- R10: `count` gives the number of bytes held, `empty` is high when the count is 0, and `full` is high when the count equals the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write value |
| fcr_q | output | 8 | Stored control value |
| fifo_mode | output | 1 | 1 = queued mode, capacity 16 |
| push_valid | input | 1 | Byte offered by the source |
| push_lb | input | 1 | Offered byte comes from the loopback path |
| push_data | input | 8 | Offered byte |
| push_ready | output | 1 | Queue can accept a byte |
| push_reject | output | 1 | Offered byte refused because the queue is full |
| overrun | output | 1 | Refused byte came from the loopback path |
| pop | input | 1 | Host data-register read |
| pop_data | output | 8 | Head byte, or 0xFF when the queue is empty |
| count | output | 5 | Number of bytes held |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | Queue holds its capacity |

## Verification
The bench fills the queue to the capacity of each mode and pushes once more. A design that takes the extra byte would corrupt the head byte or push the count past the capacity. It pops an empty queue. A design that moves the read pointer there would return stale bytes later, and a design that does not force the fill value would show old data. It switches modes with bytes in the queue and issues a receive reset in the same cycle as a push and a pop. A design that gives the push or pop priority over the flush would leave bytes behind. It sweeps all 256 control values and runs several wrap rounds with simultaneous push and pop. A wrong mask shows up in the stored value, and an off-by-one count or wrap shows up in the order of the popped bytes.

// File: rtl/rx_queue.sv
`timescale 1ns/1ps
module rx_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fcr_we,
  input  logic [7:0]                   fcr_wdata,
  output logic [7:0]                   fcr_q,
  output logic                         fifo_mode,
  input  logic                         push_valid,
  input  logic                         push_lb,
  input  logic [W-1:0]                 push_data,
  output logic                         push_ready,
  output logic                         push_reject,
  output logic                         overrun,
  input  logic                         pop,
  output logic [W-1:0]                 pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] KEEP = 8'hC9;

  logic [7:0]    ctrl;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd, wr;
  logic [CW-1:0] cnt;

  wire           on    = ctrl[0];
  wire [CW-1:0]  cap   = on ? CW'(DEPTH) : CW'(1);
  wire           flush = fcr_we && ((fcr_wdata[0] != on) || (fcr_wdata[0] && fcr_wdata[1]));
  wire           is_full  = (cnt == cap);
  wire           is_empty = (cnt == '0);
  wire           do_push  = push_valid && !is_full && !flush;
  wire           do_pop   = pop && !is_empty && !flush;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    if (!on || p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      rd   <= '0;
      wr   <= '0;
      cnt  <= '0;
    end else begin
      if (fcr_we) ctrl <= fcr_wdata[0] ? (fcr_wdata & KEEP) : 8'h00;
      if (flush) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wr <= step(wr);
        if (do_pop)  rd <= step(rd);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr] <= push_data;
  end

  assign fcr_q       = ctrl;
  assign fifo_mode   = on;
  assign push_ready  = !is_full;
  assign push_reject = push_valid && is_full && !flush;
  assign overrun     = push_reject && push_lb;
  assign pop_data    = is_empty ? {W{1'b1}} : mem[rd];
  assign count       = cnt;
  assign empty       = is_empty;
  assign full        = is_full;
endmodule

// File: rtl/rx_queue_chk.sv
`timescale 1ns/1ps
module rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fcr_we,
  input logic [7:0]                 fcr_wdata,
  input logic [7:0]                 fcr_q,
  input logic                       fifo_mode,
  input logic                       push_valid,
  input logic                       push_lb,
  input logic [W-1:0]               push_data,
  input logic                       push_ready,
  input logic                       push_reject,
  input logic                       overrun,
  input logic                       pop,
  input logic [W-1:0]               pop_data,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       empty,
  input logic                       full
);
  p_legacy_cap_r1: assert property (@(posedge clk) disable iff (!rst_n) !fifo_mode |-> count <= 1);
  p_queue_cap_r1: assert property (@(posedge clk) disable iff (!rst_n) count <= DEPTH);
  p_mode_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && (fcr_wdata[0] != fifo_mode) |=> empty && count == 0);
  p_rx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && fcr_wdata[0] && fcr_wdata[1] |=> count == 0 && fifo_mode);
  p_ctrl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && !fcr_wdata[0] |=> fcr_q == 8'h00);
  p_ctrl_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[2:1] == 2'b00 && fcr_q[5:4] == 2'b00);
  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> push_reject && push_lb);
  p_reject_full_r5: assert property (@(posedge clk) disable iff (!rst_n) push_reject |-> full);
  p_throttle_r6: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push_ready);
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && pop && !fcr_we |=> push_ready);
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push_valid && !fcr_we |=> empty);
  p_empty_data_r7: assert property (@(posedge clk) disable iff (!rst_n) empty |-> pop_data == {W{1'b1}});
  p_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready && pop && !empty && !fcr_we |=> $stable(count));
  p_flags_r10: assert property (@(posedge clk) disable iff (!rst_n) empty == (count == 0));
endmodule

bind rx_queue rx_queue_chk #(.DEPTH(DEPTH), .W(W)) u_chk (.*);

// File: tb/rx_queue_tb.sv
`timescale 1ns/1ps
module rx_queue_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       fcr_we = 0;
  logic [7:0] fcr_wdata = 0;
  logic [7:0] fcr_q;
  logic       fifo_mode;
  logic       push_valid = 0, push_lb = 0;
  logic [7:0] push_data = 0;
  logic       push_ready, push_reject, overrun;
  logic       pop = 0;
  logic [7:0] pop_data;
  logic [4:0] count;
  logic       empty, full;

  rx_queue u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mq [16];
  int mrd = 0, mwr = 0, mcnt = 0;
  bit men = 0;
  logic [7:0] mctrl = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit pv, bit lb, logic [7:0] d, bit pp, bit fw, logic [7:0] fd, string tag);
    int cap;
    bit rdy, fl, pok, wok;
    @(negedge clk);
    push_valid = pv; push_lb = lb; push_data = d; pop = pp; fcr_we = fw; fcr_wdata = fd;
    #1;
    cap = men ? 16 : 1;
    rdy = mcnt < cap;
    fl  = fw && ((fd[0] != men) || (fd[0] && fd[1]));
    chk("R6", push_ready, rdy);
    chk("R5", push_reject, pv && !rdy && !fl);
    chk("R5", overrun, pv && lb && !rdy && !fl);
    if (pp) begin
      if (mcnt == 0) chk("R7", pop_data, 8'hFF);
      else chk("R8", pop_data, mq[mrd]);
    end
    if (fw) begin
      men = fd[0];
      mctrl = fd[0] ? (fd & 8'hC9) : 8'h00;
    end
    if (fl) begin
      mrd = 0; mwr = 0; mcnt = 0;
    end else begin
      pok = pp && mcnt > 0;
      wok = pv && rdy;
      if (pok) mrd = (mrd + 1) % cap;
      if (wok) begin mq[mwr] = d; mwr = (mwr + 1) % cap; end
      mcnt = mcnt + int'(wok) - int'(pok);
    end
    @(posedge clk);
    #1;
    push_valid = 0; push_lb = 0; pop = 0; fcr_we = 0;
    cap = men ? 16 : 1;
    chk(tag, count, mcnt);
    chk("R10", empty, mcnt == 0);
    chk("R10", full, mcnt == cap);
    chk("R4", fcr_q, mctrl);
    chk("R1", fifo_mode, men);
  endtask

  task automatic push(logic [7:0] d, bit lb, string tag); cycle(1, lb, d, 0, 0, 0, tag); endtask
  task automatic popc(string tag); cycle(0, 0, 0, 1, 0, 0, tag); endtask
  task automatic fcr(logic [7:0] v, string tag); cycle(0, 0, 0, 0, 1, v, tag); endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", fifo_mode, 0);
    chk("R1", count, 0);
    chk("R10", empty, 1);
    chk("R1", pop_data, 8'hFF);

    // R1 legacy capacity, R5 rejection and overrun
    push(8'hA5, 0, "R1");
    push(8'h11, 0, "R5");
    push(8'h22, 1, "R5");
    popc("R8");
    popc("R7");
    popc("R7");
    push(8'h3C, 0, "R1");
    fcr(8'h01, "R2");
    // R6 full queue, R5 rejection
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3), 0, "R10");
    push(8'hEE, 1, "R5");
    popc("R6");
    push(8'h99, 0, "R6");
    for (int i = 0; i < 17; i++) popc("R8");
    // R8/R9 wrap rounds with simultaneous push and pop
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 11; i++) push(8'(r * 40 + i), 0, "R8");
      for (int i = 0; i < 9; i++) cycle(1, 0, 8'(200 + r * 9 + i), 1, 0, 0, "R9");
      for (int i = 0; i < 11; i++) popc("R8");
    end
    // R3 keep contents without reset, then reset
    for (int i = 0; i < 5; i++) push(8'(i + 80), 0, "R3");
    fcr(8'hC9, "R3");
    fcr(8'h43, "R3");
    // R9 flush beats push and pop
    for (int i = 0; i < 4; i++) push(8'(i + 90), 0, "R9");
    cycle(1, 0, 8'h55, 1, 1, 8'h03, "R9");
    for (int i = 0; i < 3; i++) push(8'(i + 100), 0, "R9");
    cycle(1, 1, 8'h66, 1, 1, 8'h00, "R9");
    // R4 sweep of all control values, refilling between writes
    for (int v = 0; v < 256; v++) begin
      push(8'(v), 0, "R10");
      fcr(8'(v), "R4");
    end
    // R2 switch with contents both ways
    fcr(8'h01, "R2");
    for (int i = 0; i < 6; i++) push(8'(i + 120), 0, "R2");
    fcr(8'h00, "R2");
    push(8'h77, 0, "R2");
    fcr(8'h81, "R2");
    popc("R7");
    finish_run();
  end
endmodule